// File: doc/BRIEF.md
# Register Poll Engine with Millisecond Timeout

This block polls one register of an attached port controller until a condition holds. A single start pulse loads a register address, an access width in bytes, a 16-bit mask, a 16-bit expected pattern and a budget in milliseconds. The engine then drives a generic read request towards an external register-access master. That master is outside the block and carries the reads over an I2C-like serial link. After every completed read, the engine ANDs the returned word with the mask and compares the result with the expected pattern.

The poll ends in one of four ways. It succeeds when the masked word matches. It times out when a read completes without a match after the millisecond budget has been used up. It reports an I/O error when a read fails; a failed read is not retried. It reports a bad argument when the width is illegal. A free-running prescaler derived from the clock frequency produces the millisecond tick. Only the request side of the read handshake is implemented here. Driver-level sequences use the engine to wait for conditions such as an "initialised" bit clearing, or an attach alert being raised.

Top module: `reg_poll_engine`

## Requirements
- R1: After reset, `rd_req_o`, `busy_o`, `done_o`, `ok_o`, `timeout_o`, `ioerr_o` and `badarg_o` are all 0. Whenever `done_o` is 0, all four status flags are 0.
- R2: A start with `width_i` other than 1 or 2 gives `done_o=1` and `badarg_o=1` on the next cycle, and no read request is ever raised for it.
- R3: A 1-byte read yields the word {8'h00, byte}. A 2-byte read yields {second byte, first byte}, so the first byte returned is the low byte.
- R4: When a read completes and (word & mask) == expected, the next cycle shows `done_o=1` with `ok_o=1`. This applies even if the budget is already spent. Exactly one status flag is set while `done_o` is 1.
- R5: When a read completes without a match and the elapsed count is below the budget, `rd_req_o` is low for exactly one cycle and then a new read of the same register starts.
- R6: When a read completes without a match and the elapsed count (whole ticks since start) is at least the budget, the next cycle shows `done_o=1` and `timeout_o=1`. With a budget of 0, exactly one read is made.
- R7: `rd_err_i` during a read ends the poll with `ioerr_o=1` on the next cycle, and no further read is made. If `rd_err_i` and `rd_ack_i` arrive together, the error wins.
- R8: The millisecond tick fires once every CLK_HZ/1000 cycles, counted from reset. The elapsed count advances only on a tick while busy, and it saturates at its maximum.
- R9: The result flags hold until the next accepted start. A start while `busy_o=1` is ignored and does not change the outcome.
- R10: While a read is pending (`rd_req_o=1` and no acknowledge or error yet), `rd_req_o`, `rd_addr_o` and `rd_nbytes_o` stay steady. `rd_nbytes_o` is 1 or 2. Each `rd_ack_i` delivers one byte on `rd_byte_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when not busy |
| addr_i | input | AW | Register address to poll |
| width_i | input | 3 | Access width in bytes (1 or 2 legal) |
| mask_i | input | 16 | Mask applied to the read word |
| expect_i | input | 16 | Pattern the masked word must equal |
| timeout_ms_i | input | TW | Budget in milliseconds |
| rd_req_o | output | 1 | Read request to the register-access master |
| rd_addr_o | output | AW | Register address of the pending read |
| rd_nbytes_o | output | 2 | Bytes requested (1 or 2) |
| rd_ack_i | input | 1 | One byte delivered |
| rd_err_i | input | 1 | Read failed |
| rd_byte_i | input | 8 | Delivered byte |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | Poll finished, status valid |
| ok_o | output | 1 | Masked match found |
| timeout_o | output | 1 | Budget exhausted without a match |
| ioerr_o | output | 1 | Read failure ended the poll |
| badarg_o | output | 1 | Illegal access width |

## Verification
Two pairs of events can fall in the same cycle. First, the final byte of a read can land when the budget has just run out; the match test must then win over the timeout. Second, an error and an acknowledge can arrive together; the error must then win. A zero-millisecond budget with matching data provokes the first case deterministically, and varied responder latencies move read completions across tick boundaries. An injected error together with an acknowledge provokes the second case. A behavioural model in the bench tracks the prescaler, the elapsed count and the outcome, and it is compared with the ports on every clock.

// File: rtl/poll_pkg.sv
package poll_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_GAP  = 2'd2,
    ST_DONE = 2'd3
  } poll_st_e;

  function automatic logic width_ok(input logic [2:0] w);
    return (w == 3'd1) || (w == 3'd2);
  endfunction

  function automatic logic masked_hit(input logic [WORD_W-1:0] v,
                                      input logic [WORD_W-1:0] m,
                                      input logic [WORD_W-1:0] e);
    return (v & m) == e;
  endfunction

  function automatic logic [WORD_W-1:0] join_word(input logic two,
                                                  input logic [BYTE_W-1:0] last_b,
                                                  input logic [BYTE_W-1:0] first_b);
    return two ? {last_b, first_b} : {{(WORD_W-BYTE_W){1'b0}}, last_b};
  endfunction
endpackage

// File: rtl/poll_ms_tick.sv
module poll_ms_tick #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int TICK_CYC = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int CW = (TICK_CYC < 2) ? 1 : $clog2(TICK_CYC);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(TICK_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/poll_budget_ctr.sv
module poll_budget_ctr #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [TW-1:0] limit_i,
  output logic          spent_o
);
  localparam logic [TW-1:0] SAT = '1;

  logic [TW-1:0] elapsed_q;

  assign spent_o = (elapsed_q >= limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   elapsed_q <= '0;
    else if (clear_i)                             elapsed_q <= '0;
    else if (run_i && tick_i && elapsed_q != SAT) elapsed_q <= elapsed_q + 1'b1;
  end
endmodule

// File: rtl/poll_word_asm.sv
module poll_word_asm
  import poll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              take_i,
  input  logic              two_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              last_o,
  output logic [WORD_W-1:0] word_o
);
  logic              got_q;
  logic [BYTE_W-1:0] low_q;

  assign last_o = take_i && (!two_i || got_q);
  assign word_o = join_word(two_i, byte_i, low_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q <= 1'b0;
      low_q <= '0;
    end else if (clear_i || last_o) begin
      got_q <= 1'b0;
    end else if (take_i) begin
      got_q <= 1'b1;
      low_q <= byte_i;
    end
  end
endmodule

// File: rtl/reg_poll_engine.sv
module reg_poll_engine
  import poll_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int AW     = 8,
  parameter int TW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [2:0]        width_i,
  input  logic [WORD_W-1:0] mask_i,
  input  logic [WORD_W-1:0] expect_i,
  input  logic [TW-1:0]     timeout_ms_i,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic [1:0]        rd_nbytes_o,
  input  logic              rd_ack_i,
  input  logic              rd_err_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic              timeout_o,
  output logic              ioerr_o,
  output logic              badarg_o
);
  poll_st_e          st_q;
  logic [AW-1:0]     addr_q;
  logic              two_q;
  logic [WORD_W-1:0] mask_q;
  logic [WORD_W-1:0] exp_q;
  logic [TW-1:0]     tmo_q;
  logic              done_q, ok_q, tmo_flag_q, ioerr_q, bad_q;

  // named internal events
  logic              busy_w;
  logic              start_acc_w;
  logic              take_w;
  logic              abort_w;
  logic              tick_w;
  logic              read_end_w;
  logic              hit_w;
  logic              spent_w;
  logic [WORD_W-1:0] word_w;

  assign busy_w      = (st_q == ST_READ) || (st_q == ST_GAP);
  assign start_acc_w = start_i && !busy_w;
  assign abort_w     = (st_q == ST_READ) && rd_err_i;
  assign take_w      = (st_q == ST_READ) && rd_ack_i && !rd_err_i;
  assign hit_w       = masked_hit(word_w, mask_q, exp_q);

  poll_ms_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_w)
  );

  poll_budget_ctr #(.TW(TW)) u_budget (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_acc_w),
    .run_i   (busy_w),
    .tick_i  (tick_w),
    .limit_i (tmo_q),
    .spent_o (spent_w)
  );

  poll_word_asm u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_acc_w || abort_w),
    .take_i  (take_w),
    .two_i   (two_q),
    .byte_i  (rd_byte_i),
    .last_o  (read_end_w),
    .word_o  (word_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      two_q      <= 1'b0;
      mask_q     <= '0;
      exp_q      <= '0;
      tmo_q      <= '0;
      done_q     <= 1'b0;
      ok_q       <= 1'b0;
      tmo_flag_q <= 1'b0;
      ioerr_q    <= 1'b0;
      bad_q      <= 1'b0;
    end else if (start_acc_w) begin
      addr_q     <= addr_i;
      two_q      <= (width_i == 3'd2);
      mask_q     <= mask_i;
      exp_q      <= expect_i;
      tmo_q      <= timeout_ms_i;
      ok_q       <= 1'b0;
      tmo_flag_q <= 1'b0;
      ioerr_q    <= 1'b0;
      if (width_ok(width_i)) begin
        st_q   <= ST_READ;
        done_q <= 1'b0;
        bad_q  <= 1'b0;
      end else begin
        st_q   <= ST_DONE;
        done_q <= 1'b1;
        bad_q  <= 1'b1;
      end
    end else begin
      case (st_q)
        ST_READ: begin
          if (abort_w) begin
            st_q    <= ST_DONE;
            done_q  <= 1'b1;
            ioerr_q <= 1'b1;
          end else if (read_end_w) begin
            if (hit_w) begin
              st_q   <= ST_DONE;
              done_q <= 1'b1;
              ok_q   <= 1'b1;
            end else if (spent_w) begin
              st_q       <= ST_DONE;
              done_q     <= 1'b1;
              tmo_flag_q <= 1'b1;
            end else begin
              st_q <= ST_GAP;
            end
          end
        end
        ST_GAP:  st_q <= ST_READ;
        default: st_q <= st_q;
      endcase
    end
  end

  assign rd_req_o    = (st_q == ST_READ);
  assign rd_addr_o   = addr_q;
  assign rd_nbytes_o = two_q ? 2'd2 : 2'd1;
  assign busy_o      = busy_w;
  assign done_o      = done_q;
  assign ok_o        = ok_q;
  assign timeout_o   = tmo_flag_q;
  assign ioerr_o     = ioerr_q;
  assign badarg_o    = bad_q;
endmodule

// File: rtl/poll_engine_chk.sv
module poll_engine_chk #(
  parameter int CLK_HZ = 50_000_000,
  parameter int AW     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ack_i,
  input logic          rd_err_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          ok_o,
  input logic          timeout_o,
  input logic          ioerr_o,
  input logic          badarg_o,
  input logic          tick_w,
  input logic          read_end_w,
  input logic          hit_w,
  input logic          spent_w
);
  localparam int TICK_CYC = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;

  int unsigned gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= 0;
    else if (tick_w) gap_q <= 0;
    else             gap_q <= gap_q + 1;
  end

  // R8
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_w |-> (gap_q == TICK_CYC - 1));

  // R4
  one_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones({ok_o, timeout_o, ioerr_o, badarg_o}) == 1));

  // R1
  quiet_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ({ok_o, timeout_o, ioerr_o, badarg_o} == 4'b0));

  // R2
  badarg_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    badarg_o |-> !rd_req_o);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i && !rd_err_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R7
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_err_i) |=> (done_o && ioerr_o && !rd_req_o));

  // R4
  hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_end_w && hit_w) |=> (done_o && ok_o));

  // R6
  spent_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_end_w && !hit_w && spent_w) |=> (done_o && timeout_o));

  // R5
  retry_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_end_w && !hit_w && !spent_w) |=> (!rd_req_o && busy_o) ##1 rd_req_o);

  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable({ok_o, timeout_o, ioerr_o, badarg_o})));
endmodule

bind reg_poll_engine poll_engine_chk #(.CLK_HZ(CLK_HZ), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .rd_ack_i   (rd_ack_i),
  .rd_err_i   (rd_err_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .ok_o       (ok_o),
  .timeout_o  (timeout_o),
  .ioerr_o    (ioerr_o),
  .badarg_o   (badarg_o),
  .tick_w     (tick_w),
  .read_end_w (read_end_w),
  .hit_w      (hit_w),
  .spent_w    (spent_w)
);

// File: tb/reg_poll_engine_tb_top.sv
`timescale 1ns/1ps
module reg_poll_engine_tb_top;
  localparam int CLK_HZ = 20_000;
  localparam int TICKC  = CLK_HZ / 1000;
  localparam int AW     = 8;
  localparam int TW     = 16;
  localparam int SATV   = 65535;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [2:0] width_i = '0;
  logic [15:0] mask_i = '0, expect_i = '0;
  logic [TW-1:0] timeout_ms_i = '0;
  logic rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic [1:0] rd_nbytes_o;
  logic rd_ack_i = 1'b0, rd_err_i = 1'b0;
  logic [7:0] rd_byte_i = '0;
  logic busy_o, done_o, ok_o, timeout_o, ioerr_o, badarg_o;

  always #10 clk = ~clk;

  reg_poll_engine #(.CLK_HZ(CLK_HZ), .AW(AW), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .width_i(width_i), .mask_i(mask_i), .expect_i(expect_i),
    .timeout_ms_i(timeout_ms_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_nbytes_o(rd_nbytes_o), .rd_ack_i(rd_ack_i), .rd_err_i(rd_err_i),
    .rd_byte_i(rd_byte_i), .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o),
    .timeout_o(timeout_o), .ioerr_o(ioerr_o), .badarg_o(badarg_o)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_pr, m_el, m_st, m_w, m_to, m_low;
  bit m_got, m_done, m_ok, m_tmo, m_ioe, m_bad;
  int m_addr, m_mask, m_exp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pr = 0; m_el = 0; m_st = 0; m_got = 0;
      m_done = 0; m_ok = 0; m_tmo = 0; m_ioe = 0; m_bad = 0;
      m_w = 1; m_addr = 0;
    end else begin
      bit tk, was_busy, acc;
      int word, el_before;
      tk = (m_pr == TICKC - 1);
      m_pr = tk ? 0 : m_pr + 1;
      was_busy = (m_st == 1 || m_st == 2);
      el_before = m_el;
      acc = start_i && !was_busy;
      if (acc) begin
        m_ok = 0; m_tmo = 0; m_ioe = 0; m_bad = 0; m_done = 0;
        m_addr = addr_i; m_w = width_i; m_mask = mask_i; m_exp = expect_i;
        m_to = timeout_ms_i; m_el = 0; m_got = 0;
        if (m_w == 1 || m_w == 2) m_st = 1;
        else begin m_st = 3; m_done = 1; m_bad = 1; end
      end else if (m_st == 1) begin
        if (rd_err_i) begin
          m_st = 3; m_done = 1; m_ioe = 1; m_got = 0;
        end else if (rd_ack_i) begin
          if (m_w != 2 || m_got) begin
            word = (m_w == 2) ? (int'(rd_byte_i) * 256 + m_low) : int'(rd_byte_i);
            m_got = 0;
            if ((word & m_mask) == m_exp) begin m_st = 3; m_done = 1; m_ok = 1; end
            else if (el_before >= m_to) begin m_st = 3; m_done = 1; m_tmo = 1; end
            else m_st = 2;
          end else begin
            m_low = rd_byte_i; m_got = 1;
          end
        end
      end else if (m_st == 2) begin
        m_st = 1;
      end
      if (!acc && was_busy && tk && m_el < SATV) m_el = m_el + 1;
    end
  end

  // ---------------- responder and per-cycle compare ----------------
  int lat = 0, wc = 0, bi = 0, rd_done = 0;
  int err_at = -1, err_byte = 0;
  bit err_with_ack = 0, seen_req = 0;
  logic [15:0] words [4];

  always @(negedge clk) begin
    if (rst_n) begin
      logic [6:0] act, exp;
      act = {rd_req_o, busy_o, done_o, ok_o, timeout_o, ioerr_o, badarg_o};
      exp = {m_st == 1, (m_st == 1 || m_st == 2), m_done, m_ok, m_tmo, m_ioe, m_bad};
      chk(act == exp, "R1 R4 R9 per-cycle status", int'(act), int'(exp));
      if (rd_req_o) begin
        seen_req = 1;
        chk(rd_addr_o == AW'(m_addr) && int'(rd_nbytes_o) == m_w, "R10 request fields",
            int'({rd_nbytes_o, rd_addr_o}), m_w * 256 + m_addr);
      end
    end
    if (!rd_req_o) begin
      rd_ack_i <= 0; rd_err_i <= 0; bi = 0; wc = 0;
    end else if (wc < lat) begin
      wc++; rd_ack_i <= 0; rd_err_i <= 0;
    end else begin
      logic [15:0] wv;
      wc = 0;
      wv = words[(rd_done > 3) ? 3 : rd_done];
      rd_byte_i <= (bi == 0) ? wv[7:0] : wv[15:8];
      if (rd_done == err_at && bi == err_byte) begin
        rd_err_i <= 1; rd_ack_i <= err_with_ack;
      end else begin
        rd_err_i <= 0; rd_ack_i <= 1;
        bi++;
        if (bi == int'(rd_nbytes_o)) begin bi = 0; rd_done++; end
      end
    end
  end

  task automatic setup(input int l, input logic [15:0] w0, input logic [15:0] w1);
    lat = l; words[0] = w0; words[1] = w1; words[2] = w1; words[3] = w1;
    rd_done = 0; err_at = -1; err_byte = 0; err_with_ack = 0; seen_req = 0;
  endtask

  task automatic run(input int w, input int a, input int mk, input int ex, input int to);
    @(negedge clk);
    width_i = 3'(w); addr_i = AW'(a); mask_i = 16'(mk); expect_i = 16'(ex);
    timeout_ms_i = TW'(to); start_i = 1;
    @(negedge clk);
    start_i = 0;
    for (int i = 0; i < 5000 && !done_o; i++) @(negedge clk);
  endtask

  task automatic outcome(input string tag, input bit ok, input bit tmo, input bit ioe, input bit bad);
    chk(done_o && ok_o == ok && timeout_o == tmo && ioerr_o == ioe && badarg_o == bad, tag,
        int'({done_o, ok_o, timeout_o, ioerr_o, badarg_o}), int'({1'b1, ok, tmo, ioe, bad}));
  endtask

  initial begin
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({rd_req_o, busy_o, done_o, ok_o, timeout_o, ioerr_o, badarg_o} == 0, "R1 reset",
        int'({rd_req_o, busy_o, done_o, ok_o, timeout_o, ioerr_o, badarg_o}), 0);

    // R2 illegal widths
    setup(0, 16'h0, 16'h0);
    run(0, 8'h1E, 16'h40, 0, 10);
    outcome("R2 width 0", 0, 0, 0, 1);
    run(3, 8'h1E, 16'h40, 0, 10);
    outcome("R2 width 3", 0, 0, 0, 1);
    chk(!seen_req, "R2 no read issued", int'(seen_req), 0);

    // R3 one-byte read, upper byte zero
    setup(1, 16'hFF5A, 16'hFF5A);
    run(1, 8'h1D, 16'hFFFF, 16'h005A, 5);
    outcome("R3 one-byte match", 1, 0, 0, 0);
    chk(rd_done == 1, "R3 single read", rd_done, 1);

    // R3 two-byte order, low byte first
    setup(2, 16'h1234, 16'h1234);
    run(2, 8'h10, 16'hFFFF, 16'h1234, 2);
    outcome("R3 two-byte low first", 1, 0, 0, 0);

    // R4 R5 mask: mismatch then match
    setup(0, 16'h00F0, 16'h8001);
    run(2, 8'h10, 16'h8001, 16'h8001, 50);
    outcome("R4 masked match", 1, 0, 0, 0);
    chk(rd_done == 2, "R5 retry count", rd_done, 2);

    // R6 budget exhaustion
    setup(3, 16'h0000, 16'h0000);
    run(1, 8'h1E, 16'h0040, 16'h0040, 3);
    outcome("R6 timeout", 0, 1, 0, 0);
    chk(rd_done > 1, "R5 repeated reads", rd_done, 2);

    // R6 zero budget: exactly one read
    setup(0, 16'h0000, 16'h0000);
    run(2, 8'h10, 16'h0001, 16'h0001, 0);
    outcome("R6 zero budget timeout", 0, 1, 0, 0);
    chk(rd_done == 1, "R6 one read at zero budget", rd_done, 1);

    // R4 match wins over spent budget
    setup(0, 16'h0001, 16'h0001);
    run(2, 8'h10, 16'h0001, 16'h0001, 0);
    outcome("R4 match beats spent budget", 1, 0, 0, 0);

    // R7 error mid-read, no retry
    setup(1, 16'h0000, 16'h0000);
    err_at = 1; err_byte = 1;
    run(2, 8'h10, 16'h0001, 16'h0001, 20);
    outcome("R7 io error", 0, 0, 1, 0);
    chk(rd_done == 1, "R7 no further read", rd_done, 1);

    // R7 error and ack together: error wins
    setup(0, 16'h0001, 16'h0001);
    err_at = 0; err_byte = 0; err_with_ack = 1;
    run(1, 8'h10, 16'h0001, 16'h0001, 20);
    outcome("R7 error beats ack", 0, 0, 1, 0);

    // R9 start while busy ignored, then flags hold
    setup(4, 16'h0000, 16'h0000);
    @(negedge clk);
    width_i = 3'd1; addr_i = 8'h1D; mask_i = 16'h2; expect_i = 16'h2;
    timeout_ms_i = 16'd2; start_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (8) @(negedge clk);
    width_i = 3'd0; start_i = 1;
    @(negedge clk);
    start_i = 0;
    for (int i = 0; i < 5000 && !done_o; i++) @(negedge clk);
    outcome("R9 busy start ignored", 0, 1, 0, 0);
    repeat (30) @(negedge clk);
    outcome("R9 flags hold", 0, 1, 0, 0);

    // R8 elapsed saturates: long budget ends by match later
    setup(0, 16'h0000, 16'h0004);
    run(1, 8'h1D, 16'h0004, 16'h0004, SATV);
    outcome("R8 long budget match", 1, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule